// File: doc/BRIEF.md
# Counter-and-Branch Loop Unit

This unit carries out a family of compact three-byte loop instructions. Each one names a counter register, may increment or decrement it, tests the result against zero and then either branches by a signed 9-bit displacement or falls through to the next instruction. The unit keeps its own counter registers: two 8-bit accumulators, a 16-bit pair formed by joining them, and three 16-bit index and stack registers. It returns the written-back counter value and the next program counter. No condition flags are involved.

A host pulses `start_i` with the opcode byte, the control postbyte, the displacement byte and the address of the instruction. The unit works for three cycles. In the third cycle it raises `done_o` together with the branch decision and the next program counter. The counter update is committed at the clock edge that closes that cycle. While the unit is idle, a plain load port lets the surrounding datapath write any counter register.

Top module: `loop_branch_unit`

## Requirements
- R1: Postbyte bits 7:6 choose the counter action: 2'b10 adds one, 2'b00 subtracts one, and 2'b01 only tests the register and leaves it unchanged.
- R2: Postbyte bit 5 chooses the branch sense: 0 branches when the tested value is zero, and 1 branches when it is nonzero.
- R3: Postbyte bits 2:0 choose the counter: 3'b000 = A, 3'b001 = B, 3'b100 = D, 3'b101 = X, 3'b110 = Y, 3'b111 = SP. D is A in bits 15:8 joined with B in bits 7:0. Postbyte bit 3 has no effect.
- R4: Postbyte bit 4 is the sign bit and the displacement byte gives the low eight bits of a 9-bit displacement (−256 to +255). A taken branch gives next PC = PC + 3 + displacement. A branch that is not taken gives next PC = PC + 3. All PC arithmetic wraps modulo 65536.
- R5: The zero test uses the value after the update. A and B count modulo 256 with an 8-bit test and never carry into the other accumulator. D, X, Y and SP count modulo 65536 with a 16-bit test.
- R6: A start accepted at one edge gives `done_o` high for exactly one cycle, in the third cycle after that edge. The counter is written at the edge that ends that cycle. A start arriving while busy is ignored.
- R7: Opcode byte other than 0x04, action code 2'b11, or register code 3'b010 or 3'b011 is illegal. For an illegal instruction, `illegal_o` rises with `done_o`, the branch is not taken, next PC = PC + 3, and no register changes.
- R8: The load port writes the register chosen by `ld_sel_i` (same codes as R3, A and B taking bits 7:0) when the unit is not busy. A load while busy is ignored. A load on the same edge as an accepted start is visible to that instruction.
- R9: Reset (synchronous, active high) clears every counter register and drops `busy_o` and `done_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an instruction |
| opcode_i | input | 8 | Opcode byte |
| post_i | input | 8 | Control postbyte |
| disp_i | input | 8 | Low eight bits of displacement |
| pc_i | input | 16 | Address of the instruction |
| ld_en_i | input | 1 | Register load strobe |
| ld_sel_i | input | 3 | Register to load (R3 codes) |
| ld_val_i | input | 16 | Value to load |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Final cycle of an instruction |
| taken_o | output | 1 | Branch taken (valid with done) |
| illegal_o | output | 1 | Illegal encoding (valid with done) |
| pc_next_o | output | 16 | Next program counter (valid with done) |
| a_o | output | 8 | Accumulator A |
| b_o | output | 8 | Accumulator B |
| x_o | output | 16 | Index register X |
| y_o | output | 16 | Index register Y |
| sp_o | output | 16 | Stack register SP |

## Verification
The load port and the instruction path can both act on the same register set in the same cycle. The bench forces this in two ways. First, it drives a load on the very edge that accepts a start, and expects the branch decision to be based on the freshly loaded value. Second, it drives a load in the middle of a busy instruction, and expects the register to hold the instruction's own write-back with the load discarded. A second start driven while busy is judged by counting `done_o` pulses over the following cycles and comparing the final register value.

// File: rtl/lbu_pkg.sv
package lbu_pkg;

    localparam int unsigned ADDR_W       = 16;
    localparam int unsigned WORD_W       = 16;
    localparam int unsigned BYTE_W       = 8;
    localparam int unsigned INSTR_LEN    = 3;
    localparam int unsigned INSTR_CYCLES = 3;
    localparam logic [7:0]  LOOP_OPCODE  = 8'h04;

    // counter action, postbyte bits 7:6
    typedef enum logic [1:0] {
        OP_DEC = 2'b00,
        OP_TST = 2'b01,
        OP_INC = 2'b10,
        OP_RSV = 2'b11
    } cnt_op_e;

    // counter select, postbyte bits 2:0
    typedef enum logic [2:0] {
        SEL_A  = 3'b000,
        SEL_B  = 3'b001,
        SEL_N2 = 3'b010,
        SEL_N3 = 3'b011,
        SEL_D  = 3'b100,
        SEL_X  = 3'b101,
        SEL_Y  = 3'b110,
        SEL_SP = 3'b111
    } cnt_sel_e;

    typedef struct packed {
        cnt_op_e  op;
        logic     on_nonzero;
        logic     disp_sign;
        cnt_sel_e sel;
        logic     bad;
    } loop_ctl_t;

    typedef struct packed {
        logic [BYTE_W-1:0] a;
        logic [BYTE_W-1:0] b;
        logic [WORD_W-1:0] x;
        logic [WORD_W-1:0] y;
        logic [WORD_W-1:0] sp;
    } reg_state_t;

    function automatic logic sel_unused(input cnt_sel_e s);
        return (s == SEL_N2) || (s == SEL_N3);
    endfunction

    function automatic logic sel_is_byte(input cnt_sel_e s);
        return (s == SEL_A) || (s == SEL_B);
    endfunction

    // bit 3 of the postbyte carries no meaning and is not looked at
    function automatic loop_ctl_t decode_post(input logic [7:0] opc,
                                              input logic [7:0] pb);
        loop_ctl_t c;
        c.op         = cnt_op_e'(pb[7:6]);
        c.on_nonzero = pb[5];
        c.disp_sign  = pb[4];
        c.sel        = cnt_sel_e'(pb[2:0]);
        c.bad        = (opc != LOOP_OPCODE) || (c.op == OP_RSV) || sel_unused(c.sel);
        return c;
    endfunction

    // 9-bit displacement widened to the address width
    function automatic logic [ADDR_W-1:0] widen_disp(input logic sign,
                                                     input logic [7:0] lo);
        return {{(ADDR_W-8){sign}}, lo};
    endfunction

    function automatic logic [WORD_W-1:0] read_counter(input reg_state_t st,
                                                       input cnt_sel_e s);
        logic [WORD_W-1:0] v;
        case (s)
            SEL_A:   v = {{(WORD_W-BYTE_W){1'b0}}, st.a};
            SEL_B:   v = {{(WORD_W-BYTE_W){1'b0}}, st.b};
            SEL_D:   v = {st.a, st.b};
            SEL_X:   v = st.x;
            SEL_Y:   v = st.y;
            SEL_SP:  v = st.sp;
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic reg_state_t write_counter(input reg_state_t st,
                                                 input cnt_sel_e s,
                                                 input logic [WORD_W-1:0] v);
        reg_state_t n;
        n = st;
        case (s)
            SEL_A:   n.a = v[BYTE_W-1:0];
            SEL_B:   n.b = v[BYTE_W-1:0];
            SEL_D:   begin
                n.a = v[WORD_W-1:BYTE_W];
                n.b = v[BYTE_W-1:0];
            end
            SEL_X:   n.x  = v;
            SEL_Y:   n.y  = v;
            SEL_SP:  n.sp = v;
            default: n = st;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/lbu_seq.sv
module lbu_seq
    import lbu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o,
    output logic accept_o,
    output logic done_o
);

    localparam int unsigned PH_W = (INSTR_CYCLES > 1) ? $clog2(INSTR_CYCLES) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(INSTR_CYCLES - 1);

    logic            busy_q;
    logic [PH_W-1:0] phase_q;

    assign accept_o = start_i && !busy_q;
    assign busy_o   = busy_q;
    assign done_o   = busy_q && (phase_q == PH_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            phase_q <= '0;
        end else if (accept_o) begin
            busy_q  <= 1'b1;
            phase_q <= '0;
        end else if (busy_q) begin
            if (phase_q == PH_LAST) begin
                busy_q  <= 1'b0;
                phase_q <= '0;
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    // the instruction length in cycles is fixed at three
    assert_done_latency_R6: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> ##3 done_o);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o && !busy_o);

    assert_busy_after_start_R6: assert property (@(posedge clk) disable iff (rst)
        accept_o |=> busy_o);

endmodule

// File: rtl/lbu_decode.sv
module lbu_decode
    import lbu_pkg::*;
(
    input  logic [7:0] opcode_i,
    input  logic [7:0] post_i,
    output loop_ctl_t  ctl_o
);

    assign ctl_o = decode_post(opcode_i, post_i);

    always_comb begin
        if (ctl_o.op == OP_RSV) begin
            assert_rsv_illegal_R7: assert (ctl_o.bad);
        end
    end

endmodule

// File: rtl/lbu_alu.sv
module lbu_alu
    import lbu_pkg::*;
(
    input  loop_ctl_t         ctl_i,
    input  logic [WORD_W-1:0] cur_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [7:0]        disp_i,
    output logic [WORD_W-1:0] new_o,
    output logic              zero_o,
    output logic              taken_o,
    output logic [ADDR_W-1:0] pc_next_o
);

    logic [WORD_W-1:0] adj;
    logic [ADDR_W-1:0] pc_seq;

    always_comb begin
        case (ctl_i.op)
            OP_INC:  adj = cur_i + 1'b1;
            OP_DEC:  adj = cur_i - 1'b1;
            default: adj = cur_i;
        endcase
        if (sel_is_byte(ctl_i.sel)) begin
            new_o  = {{(WORD_W-BYTE_W){1'b0}}, adj[BYTE_W-1:0]};
            zero_o = (adj[BYTE_W-1:0] == '0);
        end else begin
            new_o  = adj;
            zero_o = (adj == '0);
        end
    end

    assign taken_o   = !ctl_i.bad && (ctl_i.on_nonzero ? !zero_o : zero_o);
    assign pc_seq    = pc_i + ADDR_W'(INSTR_LEN);
    assign pc_next_o = taken_o ? pc_seq + widen_disp(ctl_i.disp_sign, disp_i) : pc_seq;

    always_comb begin
        if (ctl_i.bad) begin
            assert_bad_no_branch_R7: assert (!taken_o);
        end
    end

endmodule

// File: rtl/lbu_regfile.sv
module lbu_regfile
    import lbu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              busy_i,
    input  logic              ld_en_i,
    input  cnt_sel_e          ld_sel_i,
    input  logic [WORD_W-1:0] ld_val_i,
    input  logic              wb_en_i,
    input  cnt_sel_e          wb_sel_i,
    input  logic [WORD_W-1:0] wb_val_i,
    input  cnt_sel_e          rd_sel_i,
    output logic [WORD_W-1:0] rd_val_o,
    output reg_state_t        st_o
);

    reg_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (wb_en_i) begin
            st_q <= write_counter(st_q, wb_sel_i, wb_val_i);
        end else if (ld_en_i && !busy_i) begin
            st_q <= write_counter(st_q, ld_sel_i, ld_val_i);
        end
    end

    assign rd_val_o = read_counter(st_q, rd_sel_i);
    assign st_o     = st_q;

    assert_quiet_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy_i && !ld_en_i) |=> $stable(st_q));

    assert_no_load_when_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_i && !wb_en_i) |=> $stable(st_q));

endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
    import lbu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [7:0]  opcode_i,
    input  logic [7:0]  post_i,
    input  logic [7:0]  disp_i,
    input  logic [15:0] pc_i,
    input  logic        ld_en_i,
    input  logic [2:0]  ld_sel_i,
    input  logic [15:0] ld_val_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        taken_o,
    output logic        illegal_o,
    output logic [15:0] pc_next_o,
    output logic [7:0]  a_o,
    output logic [7:0]  b_o,
    output logic [15:0] x_o,
    output logic [15:0] y_o,
    output logic [15:0] sp_o
);

    logic              accept;
    logic              busy;
    logic              done;
    logic [7:0]        opc_q;
    logic [7:0]        post_q;
    logic [7:0]        disp_q;
    logic [ADDR_W-1:0] pc_q;
    loop_ctl_t         ctl;
    logic [WORD_W-1:0] cur_val;
    logic [WORD_W-1:0] new_val;
    logic              zero;
    logic              br_taken;
    logic [ADDR_W-1:0] pc_nx;
    logic              wb_en;
    reg_state_t        st;

    lbu_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .busy_o   (busy),
        .accept_o (accept),
        .done_o   (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            opc_q  <= '0;
            post_q <= '0;
            disp_q <= '0;
            pc_q   <= '0;
        end else if (accept) begin
            opc_q  <= opcode_i;
            post_q <= post_i;
            disp_q <= disp_i;
            pc_q   <= pc_i;
        end
    end

    lbu_decode u_dec (
        .opcode_i (opc_q),
        .post_i   (post_q),
        .ctl_o    (ctl)
    );

    lbu_alu u_alu (
        .ctl_i     (ctl),
        .cur_i     (cur_val),
        .pc_i      (pc_q),
        .disp_i    (disp_q),
        .new_o     (new_val),
        .zero_o    (zero),
        .taken_o   (br_taken),
        .pc_next_o (pc_nx)
    );

    assign wb_en = done && !ctl.bad && (ctl.op != OP_TST);

    lbu_regfile u_rf (
        .clk      (clk),
        .rst      (rst),
        .busy_i   (busy),
        .ld_en_i  (ld_en_i),
        .ld_sel_i (cnt_sel_e'(ld_sel_i)),
        .ld_val_i (ld_val_i),
        .wb_en_i  (wb_en),
        .wb_sel_i (ctl.sel),
        .wb_val_i (new_val),
        .rd_sel_i (ctl.sel),
        .rd_val_o (cur_val),
        .st_o     (st)
    );

    assign busy_o    = busy;
    assign done_o    = done;
    assign taken_o   = done && br_taken;
    assign illegal_o = done && ctl.bad;
    assign pc_next_o = pc_nx;
    assign a_o       = st.a;
    assign b_o       = st.b;
    assign x_o       = st.x;
    assign y_o       = st.y;
    assign sp_o      = st.sp;

    assert_test_keeps_R1: assert property (@(posedge clk) disable iff (rst)
        (done_o && post_q[7:6] == 2'b01) |=>
            $stable({a_o, b_o, x_o, y_o, sp_o}));

    assert_sense_R2: assert property (@(posedge clk) disable iff (rst)
        (done_o && !illegal_o) |-> (taken_o == (post_q[5] ^ zero)));

    assert_fallthrough_R4: assert property (@(posedge clk) disable iff (rst)
        (done_o && !taken_o) |-> (pc_next_o == pc_q + 16'd3));

    assert_illegal_keeps_R7: assert property (@(posedge clk) disable iff (rst)
        illegal_o |=> $stable({a_o, b_o, x_o, y_o, sp_o}));

    assert_illegal_timing_R7: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (done_o && !taken_o));

endmodule

// File: tb/loop_branch_unit_tb.sv
module loop_branch_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [7:0]  opcode_i, post_i, disp_i;
    logic [15:0] pc_i;
    logic        ld_en_i;
    logic [2:0]  ld_sel_i;
    logic [15:0] ld_val_i;
    logic        busy_o, done_o, taken_o, illegal_o;
    logic [15:0] pc_next_o;
    logic [7:0]  a_o, b_o;
    logic [15:0] x_o, y_o, sp_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    loop_branch_unit dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .opcode_i(opcode_i),
        .post_i(post_i), .disp_i(disp_i), .pc_i(pc_i), .ld_en_i(ld_en_i),
        .ld_sel_i(ld_sel_i), .ld_val_i(ld_val_i), .busy_o(busy_o),
        .done_o(done_o), .taken_o(taken_o), .illegal_o(illegal_o),
        .pc_next_o(pc_next_o), .a_o(a_o), .b_o(b_o), .x_o(x_o), .y_o(y_o),
        .sp_o(sp_o)
    );

    typedef struct packed {
        logic [7:0]  post;
        logic [7:0]  disp;
        logic [15:0] pc;
        logic [15:0] init;
        logic [15:0] expv;
        logic        tk;
        logic [15:0] epc;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{8'h80, 8'h10, 16'h1000, 16'h00FF, 16'h0000, 1'b1, 16'h1013}, // R1 inc A wraps, R2 eq
        '{8'hA1, 8'h05, 16'h2000, 16'h0001, 16'h0002, 1'b1, 16'h2008}, // R2 ne on B
        '{8'h05, 8'h20, 16'h3000, 16'h0002, 16'h0001, 1'b0, 16'h3003}, // R1 dec X, not taken
        '{8'h36, 8'hF0, 16'h4000, 16'h0005, 16'h0004, 1'b1, 16'h3FF3}, // R4 negative disp on Y
        '{8'h47, 8'h7F, 16'h5000, 16'h0000, 16'h0000, 1'b1, 16'h5082}, // R1 test SP
        '{8'h64, 8'h00, 16'h6000, 16'h0000, 16'h0000, 1'b0, 16'h6003}, // R3 test D ne
        '{8'h04, 8'h01, 16'h7000, 16'h0001, 16'h0000, 1'b1, 16'h7004}, // R3 dec D to zero
        '{8'h95, 8'h00, 16'h0010, 16'hFFFF, 16'h0000, 1'b1, 16'hFF13}, // R4 -256 and pc wrap
        '{8'h88, 8'h40, 16'h8000, 16'h0001, 16'h0002, 1'b0, 16'h8003}, // R3 bit3 ignored
        '{8'h20, 8'h02, 16'h9000, 16'h0000, 16'h00FF, 1'b1, 16'h9005}, // R5 A dec wraps to FF
        '{8'h65, 8'hFF, 16'hA000, 16'h0001, 16'h0001, 1'b1, 16'hA102}  // R4 +255
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] rd(input logic [2:0] s);
        case (s)
            3'b000:  return {8'h00, a_o};
            3'b001:  return {8'h00, b_o};
            3'b100:  return {a_o, b_o};
            3'b101:  return x_o;
            3'b110:  return y_o;
            3'b111:  return sp_o;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic load(input logic [2:0] s, input logic [15:0] v);
        @(negedge clk);
        ld_en_i = 1'b1; ld_sel_i = s; ld_val_i = v;
        @(negedge clk);
        ld_en_i = 1'b0;
    endtask

    logic r_early, r_done, r_tk, r_ill;
    logic [15:0] r_pc;

    // cl_*: load on the start edge; bl_*: load while busy
    task automatic run(input logic [7:0] opc, input logic [7:0] pb, input logic [7:0] d,
                       input logic [15:0] pc,
                       input logic cl_en, input logic [2:0] cl_sel, input logic [15:0] cl_val,
                       input logic bl_en, input logic [2:0] bl_sel, input logic [15:0] bl_val);
        @(negedge clk);
        start_i = 1'b1; opcode_i = opc; post_i = pb; disp_i = d; pc_i = pc;
        ld_en_i = cl_en; ld_sel_i = cl_sel; ld_val_i = cl_val;
        @(negedge clk);
        start_i = 1'b0;
        ld_en_i = bl_en; ld_sel_i = bl_sel; ld_val_i = bl_val;
        @(negedge clk);
        ld_en_i = 1'b0;
        r_early = done_o;
        @(negedge clk);
        r_done = done_o; r_tk = taken_o; r_ill = illegal_o; r_pc = pc_next_o;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start_i = 0; opcode_i = 8'h04; post_i = 0; disp_i = 0; pc_i = 0;
        ld_en_i = 0; ld_sel_i = 0; ld_val_i = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check("R9 regs", {a_o, b_o} | x_o | y_o | sp_o, 16'h0000);
        check("R9 busy/done", {14'h0, busy_o, done_o}, 16'h0000);

        // table walk
        for (int i = 0; i < NV; i++) begin
            load(VECS[i].post[2:0], VECS[i].init);
            run(8'h04, VECS[i].post, VECS[i].disp, VECS[i].pc, 0, 0, 0, 0, 0, 0);
            check("R6 done", {15'h0, r_done}, 16'h0001);
            check("R2 taken", {15'h0, r_tk}, {15'h0, VECS[i].tk});
            check("R4 pc", r_pc, VECS[i].epc);
            check("R5 value", rd(VECS[i].post[2:0]), VECS[i].expv);
        end

        // R6 done not early
        load(3'b101, 16'h0009);
        run(8'h04, 8'h05, 8'h00, 16'h0100, 0, 0, 0, 0, 0, 0);
        check("R6 early done", {15'h0, r_early}, 16'h0000);

        // R5 A wraps without carry into B
        load(3'b100, 16'hFF12);
        run(8'h04, 8'h80, 8'h08, 16'h0200, 0, 0, 0, 0, 0, 0);
        check("R5 A wrap", {8'h00, a_o}, 16'h0000);
        check("R5 B untouched", {8'h00, b_o}, 16'h0012);
        check("R5 taken", {15'h0, r_tk}, 16'h0001);

        // R7 reserved action code
        load(3'b101, 16'h1234);
        run(8'h04, 8'hC5, 8'h10, 16'h0300, 0, 0, 0, 0, 0, 0);
        check("R7 illegal op flag", {15'h0, r_ill}, 16'h0001);
        check("R7 illegal op no branch", {15'h0, r_tk}, 16'h0000);
        check("R7 illegal op pc", r_pc, 16'h0303);
        check("R7 illegal op X kept", x_o, 16'h1234);

        // R7 unused register code
        load(3'b000, 16'h0033);
        run(8'h04, 8'h82, 8'h10, 16'h0400, 0, 0, 0, 0, 0, 0);
        check("R7 bad reg flag", {15'h0, r_ill}, 16'h0001);
        check("R7 bad reg A kept", {8'h00, a_o}, 16'h0033);

        // R7 wrong opcode byte
        run(8'h05, 8'h85, 8'h10, 16'h0500, 0, 0, 0, 0, 0, 0);
        check("R7 bad opcode flag", {15'h0, r_ill}, 16'h0001);
        check("R7 bad opcode X kept", x_o, 16'h1234);
        check("R7 bad opcode pc", r_pc, 16'h0503);

        // R8 load while busy is discarded
        load(3'b110, 16'h0005);
        run(8'h04, 8'hA6, 8'h00, 16'h0600, 0, 0, 0, 1, 3'b110, 16'h0100);
        check("R8 busy load ignored", y_o, 16'h0006);

        // R8 load on the start edge is seen by the instruction
        load(3'b111, 16'h0007);
        run(8'h04, 8'h87, 8'h04, 16'h0700, 1, 3'b111, 16'hFFFF, 0, 0, 0);
        check("R8 same-edge load value", sp_o, 16'h0000);
        check("R8 same-edge load taken", {15'h0, r_tk}, 16'h0001);
        check("R8 same-edge load pc", r_pc, 16'h0707);

        // R6 start while busy ignored
        begin
            int dones;
            load(3'b101, 16'h0010);
            @(negedge clk);
            start_i = 1'b1; opcode_i = 8'h04; post_i = 8'h85; disp_i = 0; pc_i = 16'h0800;
            @(negedge clk);
            post_i = 8'h05;
            dones = 0;
            @(negedge clk);
            start_i = 1'b0;
            for (int k = 0; k < 8; k++) begin
                if (done_o) dones++;
                @(negedge clk);
            end
            check("R6 one done", 16'(dones), 16'h0001);
            check("R6 restart ignored", x_o, 16'h0011);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule